// File: doc/BRIEF.md
# Interrupt Context Pusher with Stack Parity Selection

When an interrupt request is accepted, this sequencer stores the processor's flag register and program counter on the active stack. One of two stack pointers is used: the user pointer or the interrupt pointer, picked by a mode bit at the moment of acceptance. The context occupies four bytes just below the initial pointer value S. The layout does not change, but how it is written does. An even pointer allows two aligned 16-bit writes. An odd pointer falls back to four single-byte writes, issued from the top byte downward.

Each write is held on a request/ready memory port until the memory accepts it. When the last write is accepted, the block pulses a completion strobe for one cycle and returns the new pointer value S-4, together with an indication of which pointer it belongs to. The surrounding core loads that value back into the selected pointer.

The controller is a three-state machine. ST_IDLE waits for a start. ST_WRITE holds the current write until ready is seen. ST_DONE gives the one-cycle completion pulse. The transitions are:
- T_ACCEPT: ST_IDLE to ST_WRITE, on start.
- T_NEXT: ST_WRITE stays in ST_WRITE, on a handshake that is not the last.
- T_LAST: ST_WRITE to ST_DONE, on the final handshake.
- T_RETURN: ST_DONE to ST_IDLE, unconditionally.

Top module: `ctx_push`

## Requirements
- R1: The pointer value S is taken from `usp_i` when `u_sel_i` is 1 and from `isp_i` when it is 0, sampled in the cycle `start_i` is accepted. Later changes of those inputs have no effect on the run.
- R2: If S[0] is 0, exactly two writes are issued, each with `mem_be_o` = 2'b11 and an even address. The lower-address byte is on `mem_wdata_o[7:0]`.
- R3: If S[0] is 1, exactly four writes are issued, each with exactly one byte enable set. Enable bit 0 is set for an even address and bit 1 for an odd address, and the byte appears on both halves of `mem_wdata_o`.
- R4: After a run, memory holds the following, with all addresses taken modulo 2^AW:
  - S-4 holds pc[7:0].
  - S-3 holds pc[15:8].
  - S-2 holds flags[7:0].
  - S-1 holds {flags[15:12], pc[19:16]}.
  - Address S is never written.
- R5: In even mode, the word at S-2 is written first and the word at S-4 second.
- R6: In odd mode, the byte addresses are S-1, S-2, S-3, S-4, in that order.
- R7: While `mem_req_o` is high and `mem_ready_i` is low, the request, address, data and enables hold steady. A new write begins only after a handshake, which is `mem_req_o` and `mem_ready_i` both high at a clock edge.
- R8: The cycle after the final handshake, `done_o` is high for exactly one cycle. In that cycle `sp_o` equals S-4 and `sp_user_o` equals the sampled `u_sel_i`.
- R9: A `start_i` while a run is in progress (in ST_WRITE or ST_DONE) is ignored. It produces no extra writes and no extra `done_o` pulse.
- R10: During and after reset, `mem_req_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Interrupt accepted; begin saving |
| u_sel_i | input | 1 | 1 selects the user pointer, 0 the interrupt pointer |
| usp_i | input | AW | User stack pointer value |
| isp_i | input | AW | Interrupt stack pointer value |
| flags_i | input | FLG_W | Flag register to save |
| pc_i | input | PC_W | Program counter to save |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | AW | Write byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_be_o | output | 2 | Byte enables, bit i for lane i |
| mem_ready_i | input | 1 | Memory accepts the current write |
| sp_o | output | AW | Updated pointer, S-4 |
| sp_user_o | output | 1 | The updated pointer belongs to the user pointer |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle:
- A fresh `start_i` can arrive while a write is still stalled waiting for `mem_ready_i`.
- The final handshake can coincide with the change of `mem_ready_i` that follows it.

The bench provokes the first case by raising `start_i` again the cycle after acceptance, with different pointers, PC and flags on the inputs. It provokes the second case by running every pointer value with both a ready that is always high and a randomly stalling ready. The result is judged by the byte image in a model memory, the order of write addresses, and the count of `done_o` pulses, which must be exactly one per run.

// File: rtl/ctx_push_pkg.sv
package ctx_push_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } push_state_e;

    // number of bytes in the saved context
    localparam int unsigned CTX_BYTES  = 4;
    localparam int unsigned WORD_STEPS = 2;
    localparam int unsigned BYTE_STEPS = 4;

endpackage

// File: rtl/ctx_push_fmt.sv
// Captures the context at acceptance and lays it out as four bytes,
// indexed by offset above S-4.
module ctx_push_fmt #(
    parameter int unsigned PC_W  = 20,
    parameter int unsigned FLG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [PC_W-1:0]      pc_i,
    input  logic [FLG_W-1:0]     flags_i,
    output logic [3:0][7:0]      img_o
);
    localparam int unsigned PC_HI = PC_W - 1;
    localparam int unsigned FL_HI = FLG_W - 1;

    logic [PC_W-1:0]  pc_q;
    logic [FLG_W-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flags_q <= '0;
        end else if (load_i) begin
            pc_q    <= pc_i;
            flags_q <= flags_i;
        end
    end

    always_comb begin
        img_o[0] = pc_q[7:0];
        img_o[1] = pc_q[15:8];
        img_o[2] = flags_q[7:0];
        img_o[3] = {flags_q[FL_HI -: 4], pc_q[PC_HI -: 4]};
    end
endmodule

// File: rtl/ctx_push_step.sv
// Maps a step index and mode onto address, data and enables.
module ctx_push_step #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0]   base_i,
    input  logic            odd_i,
    input  logic [1:0]      step_i,
    input  logic [3:0][7:0] img_i,
    output logic [AW-1:0]   addr_o,
    output logic [15:0]     wdata_o,
    output logic [1:0]      be_o
);
    logic [1:0] off;

    always_comb begin
        if (odd_i) begin
            off = 2'd3 - step_i;
        end else begin
            off = step_i[0] ? 2'd0 : 2'd2;
        end
        addr_o = base_i - AW'(4) + AW'(off);
        if (odd_i) begin
            wdata_o = {img_i[off], img_i[off]};
            be_o    = addr_o[0] ? 2'b10 : 2'b01;
        end else begin
            wdata_o = {img_i[off | 2'd1], img_i[off]};
            be_o    = 2'b11;
        end
    end
endmodule

// File: rtl/ctx_push_ctrl.sv
module ctx_push_ctrl
    import ctx_push_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          u_sel_i,
    input  logic [AW-1:0] usp_i,
    input  logic [AW-1:0] isp_i,
    input  logic          ready_i,
    output logic          accept_o,
    output logic [AW-1:0] base_o,
    output logic          odd_o,
    output logic [1:0]    step_o,
    output logic          req_o,
    output logic          done_o,
    output logic [AW-1:0] sp_o,
    output logic          user_o
);
    push_state_e   state_q, state_n;
    logic [1:0]    step_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] sp_q;
    logic          user_q;
    logic          last_step;
    logic          hs;

    assign last_step = base_q[0] ? (step_q == 2'(BYTE_STEPS - 1))
                                 : (step_q == 2'(WORD_STEPS - 1));
    assign hs        = (state_q == ST_WRITE) && ready_i;
    assign accept_o  = (state_q == ST_IDLE) && start_i;

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_n = ST_WRITE;            // T_ACCEPT
            ST_WRITE: if (ready_i && last_step) state_n = ST_DONE; // T_LAST / T_NEXT
            ST_DONE:  state_n = ST_IDLE;                          // T_RETURN
            default:  state_n = ST_IDLE;
        endcase
    end

    // state register and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            base_q  <= '0;
            sp_q    <= '0;
            user_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            if (accept_o) begin
                base_q <= u_sel_i ? usp_i : isp_i;
                user_q <= u_sel_i;
                step_q <= '0;
            end else if (hs && !last_step) begin
                step_q <= step_q + 2'd1;
            end
            if (hs && last_step) begin
                sp_q <= base_q - AW'(4);
            end
        end
    end

    // outputs
    always_comb begin
        req_o  = (state_q == ST_WRITE);
        done_o = (state_q == ST_DONE);
        base_o = base_q;
        odd_o  = base_q[0];
        step_o = step_q;
        sp_o   = sp_q;
        user_o = user_q;
    end
endmodule

// File: rtl/ctx_push.sv
module ctx_push #(
    parameter int unsigned AW    = 16,
    parameter int unsigned PC_W  = 20,
    parameter int unsigned FLG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             u_sel_i,
    input  logic [AW-1:0]    usp_i,
    input  logic [AW-1:0]    isp_i,
    input  logic [FLG_W-1:0] flags_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [15:0]      mem_wdata_o,
    output logic [1:0]       mem_be_o,
    input  logic             mem_ready_i,
    output logic [AW-1:0]    sp_o,
    output logic             sp_user_o,
    output logic             done_o
);
    logic          accept;
    logic [AW-1:0] base;
    logic          odd;
    logic [1:0]    step;
    logic [3:0][7:0] img;

    ctx_push_ctrl #(.AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .u_sel_i  (u_sel_i),
        .usp_i    (usp_i),
        .isp_i    (isp_i),
        .ready_i  (mem_ready_i),
        .accept_o (accept),
        .base_o   (base),
        .odd_o    (odd),
        .step_o   (step),
        .req_o    (mem_req_o),
        .done_o   (done_o),
        .sp_o     (sp_o),
        .user_o   (sp_user_o)
    );

    ctx_push_fmt #(.PC_W(PC_W), .FLG_W(FLG_W)) u_fmt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .pc_i    (pc_i),
        .flags_i (flags_i),
        .img_o   (img)
    );

    ctx_push_step #(.AW(AW)) u_step (
        .base_i  (base),
        .odd_i   (odd),
        .step_i  (step),
        .img_i   (img),
        .addr_o  (mem_addr_o),
        .wdata_o (mem_wdata_o),
        .be_o    (mem_be_o)
    );
endmodule

// File: rtl/ctx_push_chk.sv
module ctx_push_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [15:0]   mem_wdata_o,
    input logic [1:0]    mem_be_o,
    input logic          mem_ready_i,
    input logic [AW-1:0] sp_o,
    input logic          done_o
);
    logic [2:0]    hs_cnt;
    logic [AW-1:0] last_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_cnt    <= '0;
            last_addr <= '0;
        end else if (done_o) begin
            hs_cnt <= '0;
        end else if (mem_req_o && mem_ready_i) begin
            hs_cnt    <= hs_cnt + 3'd1;
            last_addr <= mem_addr_o;
        end
    end

    always_comb begin
        if (!rst_n) begin
            a_r10_reset_quiet: assert (!mem_req_o && !done_o);
        end
    end

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
            && $stable(mem_wdata_o) && $stable(mem_be_o));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_be_o == 2'b11 |-> !mem_addr_o[0]);

    a_r3_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_be_o != 2'b11 |-> $countones(mem_be_o) == 1
            && mem_be_o[mem_addr_o[0]] && mem_wdata_o[15:8] == mem_wdata_o[7:0]);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_write_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (hs_cnt == 3'd2 || hs_cnt == 3'd4) && !mem_req_o);

    a_r8_sp_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sp_o == last_addr);
endmodule

bind ctx_push ctx_push_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_be_o    (mem_be_o),
    .mem_ready_i (mem_ready_i),
    .sp_o        (sp_o),
    .done_o      (done_o)
);

// File: tb/test_ctx_push.sv
`timescale 1ns/100ps
module test_ctx_push;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic u_sel_i = 1'b0;
    logic [AW-1:0] usp_i = '0, isp_i = '0;
    logic [15:0] flags_i = '0;
    logic [19:0] pc_i = '0;
    logic mem_req_o, mem_ready_i = 1'b0;
    logic [AW-1:0] mem_addr_o, sp_o;
    logic [15:0] mem_wdata_o;
    logic [1:0] mem_be_o;
    logic sp_user_o, done_o;

    always #2.5 clk = ~clk;

    ctx_push i_ctx_push (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .u_sel_i(u_sel_i),
        .usp_i(usp_i), .isp_i(isp_i), .flags_i(flags_i), .pc_i(pc_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_be_o(mem_be_o), .mem_ready_i(mem_ready_i), .sp_o(sp_o),
        .sp_user_o(sp_user_o), .done_o(done_o)
    );

    int checks = 0;
    int fails = 0;
    int ready_pct = 100;
    int dones = 0;
    logic [7:0] mem [int];
    logic [AW-1:0] log_addr [$];
    logic [1:0] log_be [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // memory model and write log
    always @(posedge clk) begin
        if (done_o) dones++;
        if (mem_req_o && mem_ready_i) begin
            if (mem_be_o[0]) mem[int'({mem_addr_o[AW-1:1], 1'b0})] = mem_wdata_o[7:0];
            if (mem_be_o[1]) mem[int'({mem_addr_o[AW-1:1], 1'b1})] = mem_wdata_o[15:8];
            log_addr.push_back(mem_addr_o);
            log_be.push_back(mem_be_o);
        end
    end

    always @(negedge clk) mem_ready_i <= (($urandom % 100) < ready_pct);

    task automatic run(input logic [AW-1:0] s, input logic u,
                       input logic [19:0] pc, input logic [15:0] fl);
        logic [AW-1:0] other;
        logic [7:0] exp_b [4];
        int n_exp;
        bit seen;
        other = s ^ 16'h0F0A;
        @(negedge clk);
        mem.delete();
        log_addr.delete();
        log_be.delete();
        dones = 0;
        u_sel_i = u;
        usp_i = u ? s : other;
        isp_i = u ? other : s;
        pc_i = pc;
        flags_i = fl;
        start_i = 1'b1;
        @(negedge clk);
        // R9: second start while busy, with different inputs (R1 ignores them)
        usp_i = usp_i ^ 16'h0101;
        isp_i = isp_i ^ 16'h0101;
        u_sel_i = ~u;
        pc_i = ~pc;
        flags_i = ~fl;
        @(negedge clk);
        start_i = 1'b0;
        seen = 0;
        for (int c = 0; c < 300 && !seen; c++) begin
            if (done_o) begin
                seen = 1;
                chk(sp_o == s - 16'd4, "R8", "sp_o", sp_o, s - 16'd4);
                chk(sp_user_o == u, "R8", "sp_user_o", sp_user_o, u);
            end else begin
                @(negedge clk);
            end
        end
        chk(seen, "R8", "done seen", seen, 1);
        repeat (3) @(negedge clk);
        chk(dones == 1, "R9", "done pulses", dones, 1);
        exp_b[0] = pc[7:0];
        exp_b[1] = pc[15:8];
        exp_b[2] = fl[7:0];
        exp_b[3] = {fl[15:12], pc[19:16]};
        for (int k = 0; k < 4; k++) begin
            logic [AW-1:0] a;
            a = s - 16'd4 + AW'(k);
            chk(mem.exists(int'(a)) && mem[int'(a)] == exp_b[k], "R4", "byte image",
                mem.exists(int'(a)) ? int'(mem[int'(a)]) : -1, exp_b[k]);
        end
        chk(!mem.exists(int'(s)), "R4", "S untouched", mem.exists(int'(s)), 0);
        n_exp = s[0] ? 4 : 2;
        chk(log_addr.size() == n_exp, s[0] ? "R3" : "R2", "write count",
            log_addr.size(), n_exp);
        if (log_addr.size() == n_exp) begin
            for (int k = 0; k < n_exp; k++) begin
                logic [AW-1:0] ea;
                logic [1:0] eb;
                if (s[0]) begin
                    ea = s - AW'(k + 1);
                    eb = ea[0] ? 2'b10 : 2'b01;
                    chk(log_addr[k] == ea, "R6", "byte order", log_addr[k], ea);
                    chk(log_be[k] == eb, "R3", "byte enable", log_be[k], eb);
                end else begin
                    ea = s - AW'(2 * (k + 1));
                    chk(log_addr[k] == ea, "R5", "word order", log_addr[k], ea);
                    chk(log_be[k] == 2'b11, "R2", "word enable", log_be[k], 3);
                end
            end
        end
        chk(log_addr.size() == n_exp, "R1", "selected pointer image",
            log_addr.size() == n_exp && log_addr[log_addr.size()-1] == s - 16'd4, 1);
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pts [14];
        pts = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005,
                16'h0006, 16'h0007, 16'h0008, 16'h0009, 16'hFFFE, 16'hFFFF,
                16'h1234, 16'h1235};
        repeat (3) @(negedge clk);
        chk(!mem_req_o, "R10", "mem_req in reset", mem_req_o, 0);
        chk(!done_o, "R10", "done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_o && !done_o, "R10", "idle after reset", {mem_req_o, done_o}, 0);
        for (int m = 0; m < 2; m++) begin
            ready_pct = (m == 0) ? 100 : 40;
            for (int u = 0; u < 2; u++) begin
                for (int i = 0; i < 14; i++) begin
                    logic [AW-1:0] s;
                    s = pts[i];
                    run(s, u[0], {s[3:0] ^ 4'h5, s ^ 16'hA5C3}, s ^ 16'h7E81 ^ AW'(u * 16'h3000));
                end
            end
        end
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule